// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Sequencer

This block is the processor-side engine that turns a prioritized interrupt request into a jump to its handler. The execution core tells it when the current instruction has finished. It also supplies the live program counter, status word and stack pointer. At that instruction boundary the sequencer compares the 3-bit requested level against the priority mask held in the status word. If the request wins, the sequencer saves the return context on the stack and acknowledges the device on a per-level active-low line. It then accepts either a vector number supplied by the device or a request for the automatic vector. It fetches the handler address from the vector table and hands the core a new program counter, status word and stack pointer in a one-cycle load pulse.

The same engine executes the return-from-exception operation. It pops the saved status word and program counter and presents them through the same load pulse. All memory traffic goes through one request/acknowledge port with one access in flight. While the sequence runs, `busy` is high so the core can stall.

Top module: `intseq_top`

## Requirements
- R1: With the instruction-done strobe high and no return command, a request is taken when the level is 7, or when the level is nonzero and strictly greater than the mask in status bits 10:8. Otherwise no memory access and no load pulse follow.
- R2: The request level is looked at only in a cycle where instruction-done is high while idle. A request that is raised and then dropped to 0 before such a cycle leaves no trace.
- R3: A taken interrupt first writes the program counter as a 32-bit access at stack pointer minus 4. It then writes the status word as a 16-bit access at stack pointer minus 6 (data in bits 15:0). The stack pointer handed back is the original minus 6.
- R4: After both pushes, bit (level-1) of `iack_n` is driven low until the device answers. All other bits stay high, and every bit is high at any other time.
- R5: A device answer with `dev_vec_valid` selects `dev_vec` as the vector. An answer with `dev_auto` selects vector 24 plus the level.
- R6: The handler address is read as a 32-bit access at vector times 4 and is returned as the new program counter.
- R7: The status word returned after an interrupt equals the saved one with bits 10:8 replaced by the granted level.
- R8: A return command together with instruction-done reads the status word (16-bit) at the stack pointer, then the program counter (32-bit) at stack pointer plus 2. It returns both with stack pointer plus 6. A return command in the same cycle as a pending request takes precedence, and the request is not taken.
- R9: `mem_req` stays high with a stable address until `mem_ack`, and each access completes exactly once.
- R10: After reset the block is idle: all acknowledge lines high, no memory request, no load pulse, `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl | input | 3 | Encoded requested level, 0 means none |
| insn_done | input | 1 | Current instruction has completed |
| rte_req | input | 1 | Completing instruction is a return from exception |
| cur_pc | input | 32 | Live program counter |
| cur_sr | input | 16 | Live status word, mask in bits 10:8 |
| cur_sp | input | 32 | Live stack pointer |
| iack_n | output | 7 | Active-low acknowledge, bit i for level i+1 |
| dev_vec_valid | input | 1 | Device supplies its own vector |
| dev_vec | input | 8 | Device vector number |
| dev_auto | input | 1 | Device asks for the automatic vector |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_long | output | 1 | 1 for 32-bit access, 0 for 16-bit |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, 16-bit reads in bits 15:0 |
| ctx_load | output | 1 | One-cycle pulse: load new context |
| new_pc | output | 32 | Program counter to load |
| new_sr | output | 16 | Status word to load |
| new_sp | output | 32 | Stack pointer to load |
| busy | output | 1 | Sequence in progress |

## Verification
A return command and a pending interrupt can arrive on the same instruction-done strobe. The bench provokes this by raising `rte_req` together with a level-7 request. It judges the outcome by the first memory access, which must be a 16-bit read at the stack pointer and not a push. It also counts accesses after the load pulse, which must total exactly the two pops. A second coincidence is a request that is withdrawn exactly as the instruction completes. The bench drops the level to 0 before the done strobe and expects the memory port and the load pulse to stay silent.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PC, S_PUSH_SR, S_IACK, S_VFETCH, S_POP_SR, S_POP_PC
  } seq_state_t;

  // level 7 passes any mask; other levels must exceed it
  function automatic logic grant_ok(input logic [2:0] lvl, input logic [2:0] mask);
    return (lvl != 3'd0) && ((lvl == 3'd7) || (lvl > mask));
  endfunction

  function automatic logic [7:0] pick_vec(input logic autov, input logic [7:0] dv,
                                          input logic [2:0] lvl, input int base);
    return autov ? (8'(base) + {5'b0, lvl}) : dv;
  endfunction

  function automatic logic [31:0] tbl_addr(input logic [7:0] v);
    return {22'b0, v, 2'b00};
  endfunction

  function automatic logic [15:0] set_mask(input logic [15:0] sr, input logic [2:0] lvl);
    return {sr[15:11], lvl, sr[7:0]};
  endfunction

endpackage

// File: rtl/intseq_grant.sv
module intseq_grant
  import intseq_pkg::*;
(
  input  logic [2:0] lvl,
  input  logic [2:0] mask,
  output logic       ok
);
  assign ok = grant_ok(lvl, mask);

  always_comb begin
    // R1: a zero level is never a request
    a_zero_r1: assert (!(ok && lvl == 3'd0));
  end
endmodule

// File: rtl/intseq_ackdrv.sv
module intseq_ackdrv #(
  parameter int NLVL = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [2:0]      lvl,
  output logic [NLVL-1:0] iack_n
);
  for (genvar i = 0; i < NLVL; i++) begin : g_line
    assign iack_n[i] = !(active && (lvl == 3'(i + 1)));
  end

  // R4: never more than one acknowledge line low
  p_iack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~iack_n));
endmodule

// File: rtl/intseq_top.sv
module intseq_top
  import intseq_pkg::*;
#(
  parameter int NLVL      = 7,
  parameter int AUTO_BASE = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      irq_lvl,
  input  logic            insn_done,
  input  logic            rte_req,
  input  logic [31:0]     cur_pc,
  input  logic [15:0]     cur_sr,
  input  logic [31:0]     cur_sp,
  output logic [NLVL-1:0] iack_n,
  input  logic            dev_vec_valid,
  input  logic [7:0]      dev_vec,
  input  logic            dev_auto,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_long,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            ctx_load,
  output logic [31:0]     new_pc,
  output logic [15:0]     new_sr,
  output logic [31:0]     new_sp,
  output logic            busy
);
  localparam logic [31:0] PC_BYTES = 32'd4;
  localparam logic [31:0] SR_BYTES = 32'd2;
  localparam logic [31:0] FRAME    = PC_BYTES + SR_BYTES;

  seq_state_t  state;
  logic [2:0]  lvl_q;
  logic [31:0] pc_q, sp_q;
  logic [15:0] sr_q;
  logic [7:0]  vec_q;
  logic        was_rte;

  // named internal events
  logic grant_hit, take_irq, take_rte, acc_done, dev_answer, in_iack;

  intseq_grant u_grant (.lvl(irq_lvl), .mask(cur_sr[10:8]), .ok(grant_hit));

  assign take_rte   = (state == S_IDLE) && insn_done && rte_req;
  assign take_irq   = (state == S_IDLE) && insn_done && !rte_req && grant_hit;
  assign acc_done   = mem_req && mem_ack;
  assign dev_answer = dev_auto || dev_vec_valid;
  assign in_iack    = (state == S_IACK);
  assign busy       = (state != S_IDLE);

  intseq_ackdrv #(.NLVL(NLVL)) u_ack (
    .clk(clk), .rst_n(rst_n), .active(in_iack), .lvl(lvl_q), .iack_n(iack_n));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_long  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_PC: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_long = 1'b1;
        mem_addr = sp_q - PC_BYTES; mem_wdata = pc_q;
      end
      S_PUSH_SR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp_q - FRAME; mem_wdata = {16'h0, sr_q};
      end
      S_VFETCH: begin
        mem_req = 1'b1; mem_long = 1'b1; mem_addr = tbl_addr(vec_q);
      end
      S_POP_SR: begin
        mem_req = 1'b1; mem_addr = sp_q;
      end
      S_POP_PC: begin
        mem_req = 1'b1; mem_long = 1'b1; mem_addr = sp_q + SR_BYTES;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lvl_q    <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
      sr_q     <= '0;
      vec_q    <= '0;
      was_rte  <= 1'b0;
      ctx_load <= 1'b0;
      new_pc   <= '0;
      new_sr   <= '0;
      new_sp   <= '0;
    end else begin
      ctx_load <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (take_rte) begin
            sp_q    <= cur_sp;
            was_rte <= 1'b1;
            state   <= S_POP_SR;
          end else if (take_irq) begin
            lvl_q   <= irq_lvl;
            pc_q    <= cur_pc;
            sr_q    <= cur_sr;
            sp_q    <= cur_sp;
            was_rte <= 1'b0;
            state   <= S_PUSH_PC;
          end
        end
        S_PUSH_PC: if (acc_done) state <= S_PUSH_SR;
        S_PUSH_SR: if (acc_done) state <= S_IACK;
        S_IACK: if (dev_answer) begin
          vec_q <= pick_vec(dev_auto, dev_vec, lvl_q, AUTO_BASE);
          state <= S_VFETCH;
        end
        S_VFETCH: if (acc_done) begin
          new_pc   <= mem_rdata;
          new_sr   <= set_mask(sr_q, lvl_q);
          new_sp   <= sp_q - FRAME;
          ctx_load <= 1'b1;
          state    <= S_IDLE;
        end
        S_POP_SR: if (acc_done) begin
          sr_q  <= mem_rdata[15:0];
          state <= S_POP_PC;
        end
        S_POP_PC: if (acc_done) begin
          new_pc   <= mem_rdata;
          new_sr   <= sr_q;
          new_sp   <= sp_q + FRAME;
          ctx_load <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: a qualifying request starts the push sequence
  p_grant_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && insn_done && !rte_req && irq_lvl != 3'd0 &&
     (irq_lvl == 3'd7 || irq_lvl > cur_sr[10:8])) |=> state == S_PUSH_PC);
  // R1: a masked request leaves the block idle
  p_grant_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && insn_done && !rte_req &&
     !(irq_lvl == 3'd7 || (irq_lvl != 3'd0 && irq_lvl > cur_sr[10:8]))) |=> state == S_IDLE);
  // R2: nothing starts without the instruction-done strobe
  p_wait_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !insn_done) |=> state == S_IDLE);
  // R3: program counter push is followed by status push
  p_push_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_PC && mem_ack) |=> state == S_PUSH_SR);
  // R4: acknowledge only while awaiting the device
  p_iack_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (~iack_n != '0) |-> (state == S_IACK && !mem_req));
  // R7: mask field raised to the granted level
  p_mask_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && !was_rte) |-> new_sr[10:8] == lvl_q);
  // R8: return command wins over a pending request
  p_rte_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && insn_done && rte_req) |=> state == S_POP_SR);
  // R9: request held with a stable address until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R10: no load pulse while a sequence is still running
  p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> state == S_IDLE);
endmodule

// File: tb/tb_intseq_top.sv
module tb_intseq_top;
  localparam int CLK_PERIOD = 10;

  // entry: {level, mask, auto, device vector, expected vector}
  localparam logic [22:0] VEC_TBL [7] = '{
    {3'd1, 3'd0, 1'b1, 8'h00, 8'd25},
    {3'd4, 3'd3, 1'b0, 8'h40, 8'd64},
    {3'd7, 3'd7, 1'b1, 8'h00, 8'd31},
    {3'd7, 3'd6, 1'b0, 8'hFF, 8'd255},
    {3'd5, 3'd4, 1'b0, 8'h00, 8'd0},
    {3'd3, 3'd2, 1'b1, 8'h99, 8'd27},
    {3'd6, 3'd0, 1'b0, 8'h80, 8'd128}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  irq_lvl = '0;
  logic        insn_done = 1'b0, rte_req = 1'b0;
  logic [31:0] cur_pc = '0, cur_sp = '0;
  logic [15:0] cur_sr = '0;
  logic [6:0]  iack_n;
  logic        dev_vec_valid = 1'b0, dev_auto = 1'b0;
  logic [7:0]  dev_vec = '0;
  logic        mem_req, mem_we, mem_long, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        ctx_load, busy;
  logic [31:0] new_pc, new_sp;
  logic [15:0] new_sr;

  int total = 0, bad = 0, nacc = 0, nload = 0;
  logic [31:0] a_addr [4];
  logic [31:0] a_data [4];
  logic        a_we [4];
  logic        a_long [4];
  logic [6:0]  seen_iack = 7'h7f;
  logic        cfg_auto = 1'b0;
  logic [7:0]  cfg_vec = '0;
  logic [31:0] g_pc = '0, g_sp = '0;
  logic [15:0] g_sr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intseq_top dut (.*);

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C3C, ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one-cycle acknowledge, logs the first accesses
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (nacc < 4) begin
        a_addr[nacc] = mem_addr; a_data[nacc] = mem_wdata;
        a_we[nacc] = mem_we; a_long[nacc] = mem_long;
      end
      nacc++;
      mem_rdata = rd_pat(mem_addr);
      mem_ack = 1'b1;
    end
  end

  // device responder
  initial forever begin
    @(negedge clk);
    if (dev_auto || dev_vec_valid) begin
      dev_auto = 1'b0; dev_vec_valid = 1'b0;
    end else if (iack_n != 7'h7f) begin
      seen_iack = iack_n;
      if (cfg_auto) dev_auto = 1'b1;
      else begin dev_vec = cfg_vec; dev_vec_valid = 1'b1; end
    end
  end

  // load watcher
  initial forever begin
    @(negedge clk);
    if (ctx_load) begin g_pc = new_pc; g_sr = new_sr; g_sp = new_sp; nload++; end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic strobe(input logic [2:0] lvl, input logic [2:0] mask, input logic rte,
                        input logic [31:0] sp, input logic [31:0] pc);
    @(negedge clk);
    nacc = 0; seen_iack = 7'h7f;
    cur_sp = sp; cur_pc = pc;
    cur_sr = 16'h2000 | (16'(mask) << 8) | 16'h0015;
    irq_lvl = lvl; rte_req = rte; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; rte_req = 1'b0;
  endtask

  task automatic wait_load(input int n0);
    for (int k = 0; k < 100 && nload == n0; k++) @(negedge clk);
  endtask

  task automatic run_irq(input logic [2:0] lvl, input logic [2:0] mask, input logic autov,
                         input logic [7:0] dv, input logic [7:0] expv);
    int n0;
    logic [31:0] sp, pc;
    logic [15:0] sr;
    sp = 32'h0000_8000; pc = 32'h0012_3450 + 32'(lvl);
    sr = 16'h2000 | (16'(mask) << 8) | 16'h0015;
    cfg_auto = autov; cfg_vec = dv;
    n0 = nload;
    strobe(lvl, mask, 1'b0, sp, pc);
    irq_lvl = 3'd0;
    wait_load(n0);
    chk("R3 pc push addr", a_addr[0], sp - 4);
    chk("R3 pc push data", a_data[0], pc);
    chk("R3 pc push kind", {30'b0, a_we[0], a_long[0]}, 32'd3);
    chk("R3 sr push addr", a_addr[1], sp - 6);
    chk("R3 sr push data", {16'h0, a_data[1][15:0]}, {16'h0, sr});
    chk("R3 sr push kind", {30'b0, a_we[1], a_long[1]}, 32'd2);
    chk("R4 iack line", {25'b0, seen_iack}, {25'b0, ~(7'b1 << (lvl - 3'd1))});
    chk("R5 R6 table addr", a_addr[2], {22'b0, expv, 2'b00});
    chk("R6 new pc", g_pc, rd_pat({22'b0, expv, 2'b00}));
    chk("R7 new sr", {16'h0, g_sr}, {16'h0, sr[15:11], lvl, sr[7:0]});
    chk("R3 new sp", g_sp, sp - 6);
    chk("R9 access count", nacc, 3);
  endtask

  task automatic run_reject(input logic [2:0] lvl, input logic [2:0] mask);
    int n0;
    n0 = nload;
    strobe(lvl, mask, 1'b0, 32'h0000_8000, 32'h1000);
    irq_lvl = 3'd0;
    repeat (8) @(negedge clk);
    chk("R1 masked no access", nacc, 0);
    chk("R1 masked no load", nload, n0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 iack idle", {25'b0, iack_n}, 32'h7f);
    chk("R10 no req", {31'b0, mem_req}, 0);
    chk("R10 no load", {31'b0, ctx_load}, 0);
    chk("R10 not busy", {31'b0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      logic [22:0] e;
      e = VEC_TBL[i];
      run_irq(e[22:20], e[19:17], e[16], e[15:8], e[7:0]);
    end

    // R1 boundaries: equal level, lower level, level 0
    run_reject(3'd3, 3'd3);
    run_reject(3'd2, 3'd5);
    run_reject(3'd0, 3'd0);

    // R2: request withdrawn before the instruction completes
    begin
      int n0;
      n0 = nload;
      @(negedge clk); nacc = 0; cur_sr = 16'h2000; irq_lvl = 3'd5;
      repeat (5) @(negedge clk);
      chk("R2 no access without done", nacc, 0);
      irq_lvl = 3'd0; insn_done = 1'b1;
      @(negedge clk); insn_done = 1'b0;
      repeat (8) @(negedge clk);
      chk("R2 withdrawn no access", nacc, 0);
      chk("R2 withdrawn no load", nload, n0);
    end

    // R8 return from exception
    begin
      int n0;
      logic [31:0] sp;
      sp = 32'h0000_7FFA;
      n0 = nload;
      strobe(3'd0, 3'd0, 1'b1, sp, 32'h0);
      wait_load(n0);
      chk("R8 sr pop addr", a_addr[0], sp);
      chk("R8 sr pop kind", {30'b0, a_we[0], a_long[0]}, 32'd0);
      chk("R8 pc pop addr", a_addr[1], sp + 2);
      chk("R8 pc pop kind", {30'b0, a_we[1], a_long[1]}, 32'd1);
      chk("R8 restored sr", {16'h0, g_sr}, {16'h0, rd_pat(sp)[15:0]});
      chk("R8 restored pc", g_pc, rd_pat(sp + 2));
      chk("R8 restored sp", g_sp, sp + 6);
    end

    // R8 return and level-7 request on the same strobe
    begin
      int n0;
      n0 = nload;
      cfg_auto = 1'b1;
      strobe(3'd7, 3'd0, 1'b1, 32'h0000_6000, 32'h4444);
      irq_lvl = 3'd0;
      wait_load(n0);
      repeat (6) @(negedge clk);
      chk("R8 precedence first is read", {31'b0, a_we[0]}, 0);
      chk("R8 precedence first addr", a_addr[0], 32'h0000_6000);
      chk("R8 precedence pops only", nacc, 2);
      chk("R4 no iack on return", {25'b0, seen_iack}, 32'h7f);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule